// File: doc/BRIEF.md
# NAND Flash Single-Register Bridge

This block lets a processor operate a raw 8-bit NAND flash device through one 32-bit register on a small synchronous bus. Each register write holds a chip-enable flag, a three-bit operation code and one byte. The bridge turns that write into a single command-latch, address-latch or data-write strobe on the flash pins. Software builds a page program or a block erase from a series of such writes, and it polls the busy bit between steps.

One operation code starts no flash cycle. It only sets a sticky read mode. While read mode is set, every register read produces one read strobe and returns the byte the flash drives. Outside read mode, a read returns status only. Every read reports the device busy state. The ready/busy pin is synchronised first. The host holds its request until a one-cycle ready pulse. For a strobe cycle, that pulse comes only after the strobe's low time and its hold time have both elapsed.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, chip select is inactive (`nand_ce_n`=1), `nand_we_n`=1, `nand_re_n`=1, `nand_cle`=0, `nand_ale`=0, `nand_io_oe`=0, `bus_ready`=0, and read mode is off.
- R2: A write whose bits 30:28 equal 0 produces exactly one write strobe. During that strobe `nand_cle`=1, `nand_ale`=0 and `nand_io_out` equals bits 23:16 of the written word.
- R3: A write whose bits 30:28 equal 1 produces exactly one write strobe. During that strobe `nand_ale`=1, `nand_cle`=0 and `nand_io_out` equals bits 23:16.
- R4: A write whose bits 30:28 equal 3 produces exactly one write strobe. During that strobe `nand_cle`=0, `nand_ale`=0 and `nand_io_out` equals bits 23:16.
- R5: On every write with an operation code of 0 to 3, `nand_ce_n` takes the inverse of bit 31. A write with bit 31 clear therefore leaves chip select inactive during its strobe.
- R6: A write with operation code 2 produces no strobe and sets read mode. Each register read in read mode produces one `nand_re_n` strobe. The read returns the byte present on `nand_io_in` in the last cycle before `nand_re_n` rises, placed in bits 23:16.
- R7: Read mode is cleared by the next write with operation code 0, 1 or 3. A read made outside read mode strobes nothing and returns only the status bit.
- R8: A write with operation code 4 to 7 is acknowledged. It produces no strobe and leaves chip select and read mode unchanged.
- R9: Bit 15 of every read word is 1 while `nand_rb_n` is low and 0 while it is high. The pin is seen through two synchronising flops, so a change shows within three cycles. All read-word bits other than 23:16 and 15 are 0.
- R10: A strobe stays low for LOW_CYC cycles and is then held high for HIGH_CYC cycles before `bus_ready` pulses. A strobe transfer is therefore acknowledged LOW_CYC+HIGH_CYC+1 clock edges after acceptance, and a transfer with no strobe is acknowledged on the accepting edge. `bus_ready` is high for one cycle only.
- R11: `nand_io_oe` is high only during write strobe cycles and is low whenever `nand_re_n` is low. `nand_we_n` and `nand_re_n` are never low together, and `nand_cle` and `nand_ale` are never high together. While a write strobe is low, the I/O byte and the latch lines hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host request, held until bus_ready |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_wdata | input | 32 | Register write word |
| bus_rdata | output | 32 | Register read word, valid with bus_ready |
| bus_ready | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven to flash I/O |
| nand_io_oe | output | 1 | Output enable for the I/O byte |
| nand_io_in | input | 8 | Byte read from flash I/O |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
The checker module watches the pin-level rules on every cycle. These rules are: the two strobes are never low together, the I/O is released during a read strobe, the latch lines are exclusive, the byte and latch lines hold steady through a write strobe, the ready pulse lasts one cycle, and the pins reach their idle levels after reset.

The bench scenarios cover the rest, which depends on the sequence of transactions. They check the mapping from operation code to latch lines and byte, and the inversion of chip enable. They check that read mode persists and then clears, that reserved codes have no effect, and where read data is captured relative to the rising read strobe. They also check strobe widths, acknowledge latency, and the delay of the busy bit through the synchroniser.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int EN_POS   = 31;
  localparam int OP_HI    = 30;
  localparam int OP_LO    = 28;
  localparam int BYTE_LO  = 16;
  localparam int BUSY_POS = 15;

  typedef enum logic [2:0] {
    OP_CMD  = 3'd0,
    OP_ADDR = 3'd1,
    OP_READ = 3'd2,
    OP_DATA = 3'd3
  } nrb_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_ACK  = 2'd2
  } nrb_state_e;

  typedef struct packed {
    logic              enable;
    logic              is_latch_wr;
    logic              is_read_sel;
    logic              is_reserved;
    logic              cle;
    logic              ale;
    logic [BYTE_W-1:0] data;
  } nrb_cmd_t;
endpackage

// File: rtl/nrb_sync.sv
module nrb_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nrb_decode.sv
module nrb_decode
  import nrb_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output nrb_cmd_t          cmd
);
  logic [2:0] op;

  always_comb begin
    op              = word[OP_HI:OP_LO];
    cmd             = '0;
    cmd.enable      = word[EN_POS];
    cmd.data        = word[BYTE_LO +: BYTE_W];
    cmd.is_reserved = op[2];
    cmd.is_read_sel = (op == OP_READ);
    cmd.is_latch_wr = (op == OP_CMD) || (op == OP_ADDR) || (op == OP_DATA);
    cmd.cle         = (op == OP_CMD);
    cmd.ale         = (op == OP_ADDR);
  end
endmodule

// File: rtl/nrb_strobe_timer.sv
module nrb_strobe_timer #(
  parameter int LOW_CYC  = 3,
  parameter int HIGH_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic in_low,
  output logic in_high,
  output logic last_low,
  output logic done
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CW-1:0] LOW_LOAD  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LOAD = CW'(HIGH_CYC - 1);

  logic [CW-1:0] cnt;

  assign last_low = in_low  && (cnt == '0);
  assign done     = in_high && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_low  <= 1'b0;
      in_high <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      in_low  <= 1'b1;
      in_high <= 1'b0;
      cnt     <= LOW_LOAD;
    end else if (last_low) begin
      in_low  <= 1'b0;
      in_high <= 1'b1;
      cnt     <= HIGH_LOAD;
    end else if (done) begin
      in_high <= 1'b0;
    end else if (in_low || in_high) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/nand_reg_bridge.sv
module nand_reg_bridge
  import nrb_pkg::*;
#(
  parameter int LOW_CYC    = 3,
  parameter int HIGH_CYC   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [BYTE_W-1:0] nand_io_out,
  output logic              nand_io_oe,
  input  logic [BYTE_W-1:0] nand_io_in,
  input  logic              nand_rb_n
);
  nrb_state_e state;
  nrb_cmd_t   dec;
  logic       read_mode;
  logic       rd_xfer;
  logic       rb_sync;
  logic       busy;
  logic       tmr_start, tmr_low, tmr_high, tmr_last_low, tmr_done;
  logic       accept;
  logic       start_wr, start_rd;

  nrb_decode u_dec (
    .word (bus_wdata),
    .cmd  (dec)
  );

  nrb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rb_sync (
    .clk (clk),
    .rst (rst),
    .d   (nand_rb_n),
    .q   (rb_sync)
  );

  assign busy = ~rb_sync;

  assign accept    = (state == ST_IDLE) && bus_sel;
  assign start_wr  = accept && bus_we && dec.is_latch_wr;
  assign start_rd  = accept && !bus_we && read_mode;
  assign tmr_start = start_wr || start_rd;

  nrb_strobe_timer #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_tmr (
    .clk      (clk),
    .rst      (rst),
    .start    (tmr_start),
    .in_low   (tmr_low),
    .in_high  (tmr_high),
    .last_low (tmr_last_low),
    .done     (tmr_done)
  );

  function automatic logic [WORD_W-1:0] status_word(input logic b);
    logic [WORD_W-1:0] w;
    w = '0;
    w[BUSY_POS] = b;
    return w;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      read_mode   <= 1'b0;
      rd_xfer     <= 1'b0;
      bus_ready   <= 1'b0;
      bus_rdata   <= '0;
      nand_ce_n   <= 1'b1;
      nand_cle    <= 1'b0;
      nand_ale    <= 1'b0;
      nand_we_n   <= 1'b1;
      nand_re_n   <= 1'b1;
      nand_io_out <= '0;
      nand_io_oe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (bus_we) begin
              if (dec.is_latch_wr) begin
                nand_ce_n   <= ~dec.enable;
                nand_cle    <= dec.cle;
                nand_ale    <= dec.ale;
                nand_io_out <= dec.data;
                nand_io_oe  <= 1'b1;
                nand_we_n   <= 1'b0;
                read_mode   <= 1'b0;
                rd_xfer     <= 1'b0;
                state       <= ST_XFER;
              end else begin
                if (dec.is_read_sel) begin
                  nand_ce_n <= ~dec.enable;
                  read_mode <= 1'b1;
                end
                bus_rdata <= status_word(busy);
                bus_ready <= 1'b1;
                state     <= ST_ACK;
              end
            end else if (read_mode) begin
              nand_io_oe <= 1'b0;
              nand_re_n  <= 1'b0;
              rd_xfer    <= 1'b1;
              state      <= ST_XFER;
            end else begin
              bus_rdata <= status_word(busy);
              bus_ready <= 1'b1;
              state     <= ST_ACK;
            end
          end
        end
        ST_XFER: begin
          if (tmr_last_low) begin
            nand_we_n <= 1'b1;
            nand_re_n <= 1'b1;
            if (rd_xfer) bus_rdata[BYTE_LO +: BYTE_W] <= nand_io_in;
          end
          if (tmr_done) begin
            if (!rd_xfer) bus_rdata[BYTE_LO +: BYTE_W] <= '0;
            bus_rdata[BUSY_POS] <= busy;
            bus_ready <= 1'b1;
            state     <= ST_ACK;
          end
        end
        ST_ACK: begin
          bus_ready  <= 1'b0;
          nand_io_oe <= 1'b0;
          nand_cle   <= 1'b0;
          nand_ale   <= 1'b0;
          rd_xfer    <= 1'b0;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic unused_tmr;
  assign unused_tmr = tmr_low ^ tmr_high;
endmodule

// File: rtl/nrb_checks.sv
module nrb_checks (
  input logic       clk,
  input logic       rst,
  input logic       bus_ready,
  input logic       nand_ce_n,
  input logic       nand_cle,
  input logic       nand_ale,
  input logic       nand_we_n,
  input logic       nand_re_n,
  input logic [7:0] nand_io_out,
  input logic       nand_io_oe
);
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!nand_we_n && !nand_re_n)); // R11

  AST_IO_RELEASED_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !nand_re_n |-> !nand_io_oe); // R11

  AST_LATCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(nand_cle && nand_ale)); // R11

  AST_WE_IMPLIES_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !nand_we_n |-> nand_io_oe); // R11

  AST_WE_LOW_STEADY: assert property (@(posedge clk) disable iff (rst)
    (!nand_we_n && !$past(nand_we_n)) |->
      ($stable(nand_io_out) && $stable(nand_cle) && $stable(nand_ale) && $stable(nand_ce_n))); // R11

  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R10

  AST_READY_NOT_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> (nand_we_n && nand_re_n)); // R10

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nand_ce_n && nand_we_n && nand_re_n && !nand_io_oe
                    && !nand_cle && !nand_ale && !bus_ready)); // R1
endmodule

bind nand_reg_bridge nrb_checks u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_ready   (bus_ready),
  .nand_ce_n   (nand_ce_n),
  .nand_cle    (nand_cle),
  .nand_ale    (nand_ale),
  .nand_we_n   (nand_we_n),
  .nand_re_n   (nand_re_n),
  .nand_io_out (nand_io_out),
  .nand_io_oe  (nand_io_oe)
);

// File: tb/sim_nand_reg_bridge.sv
`timescale 1ns/1ps
module sim_nand_reg_bridge;
  localparam int TL = 3;
  localparam int TH = 3;
  localparam int STROBE_LAT = TL + TH + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in;
  logic        nand_rb_n = 1'b1;
  logic [7:0]  fl_byte = 8'h00;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int we_falls = 0, re_falls = 0, we_low = 0, re_low = 0;
  logic cap_cle, cap_ale, cap_ce_n, cap_oe;
  logic [7:0] cap_io;

  always #4 clk = ~clk;

  assign nand_io_in = nand_re_n ? ~fl_byte : fl_byte;

  nand_reg_bridge #(.LOW_CYC(TL), .HIGH_CYC(TH)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  always @(negedge nand_we_n) if (rst === 1'b0) we_falls++;
  always @(negedge nand_re_n) if (rst === 1'b0) re_falls++;
  always @(posedge clk) if (rst === 1'b0) begin
    if (nand_we_n === 1'b0) we_low++;
    if (nand_re_n === 1'b0) re_low++;
  end
  always @(posedge nand_we_n) if (rst === 1'b0) begin
    cap_cle = nand_cle; cap_ale = nand_ale; cap_ce_n = nand_ce_n;
    cap_oe = nand_io_oe; cap_io = nand_io_out;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    we_falls = 0; re_falls = 0; we_low = 0; re_low = 0;
  endtask

  task automatic xfer(input bit we, input logic [31:0] wd,
                      output logic [31:0] rd, output int lat);
    @(negedge clk);
    clear_mon();
    bus_sel = 1'b1; bus_we = we; bus_wdata = wd; lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (bus_ready) break;
    end
    rd = bus_rdata;
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] mkw(input bit en, input int op, input logic [7:0] d);
    return {en, op[2:0], 4'h0, d, 16'h0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat;
    logic prev_ce;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, bus_ready} == 7'b1110000,
        "R1", "idle pins", {25'h0, nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_io_oe, bus_ready},
        32'h70);
    // R7 read mode off after reset
    xfer(1'b0, '0, rd, lat);
    chk(re_falls == 0 && rd == 32'h0, "R7", "read before read mode", rd, 32'h0);

    // R2 R3 R4 R5 R10 sweep
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      for (int en = 0; en < 2; en++) begin
        for (int d = 0; d < 256; d += 15) begin
          string rq;
          rq = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
          xfer(1'b1, mkw(en[0], op, d[7:0]), rd, lat);
          chk(we_falls == 1 && re_falls == 0, rq, "strobe count", we_falls, 1);
          chk(cap_cle == (op == 0) && cap_ale == (op == 1) && cap_oe == 1'b1, rq, "latch lines",
              {29'h0, cap_cle, cap_ale, cap_oe}, {29'h0, op == 0, op == 1, 1'b1});
          chk(cap_io == d[7:0], rq, "io byte", cap_io, d);
          chk(cap_ce_n == ~en[0], "R5", "chip enable", cap_ce_n, ~en[0]);
          chk(we_low == TL && lat == STROBE_LAT, "R10", "timing", {we_low[15:0], lat[15:0]},
              {TL[15:0], STROBE_LAT[15:0]});
          chk(nand_io_oe == 1'b0, "R11", "io released after write", nand_io_oe, 0);
        end
      end
    end

    // R6 enter read mode
    xfer(1'b1, mkw(1'b1, 2, 8'h77), rd, lat);
    chk(we_falls == 0 && re_falls == 0 && lat == 1, "R6", "read select no strobe", lat, 1);
    chk(nand_ce_n == 1'b0, "R5", "ce from read select", nand_ce_n, 0);
    for (int i = 0; i < 16; i++) begin
      fl_byte = 8'(i * 37 + 11);
      xfer(1'b0, '0, rd, lat);
      chk(rd == {8'h0, fl_byte, 16'h0}, "R6", "read data", rd, {8'h0, fl_byte, 16'h0});
      chk(re_falls == 1 && we_falls == 0, "R6", "one read strobe", re_falls, 1);
      chk(re_low == TL && lat == STROBE_LAT, "R10", "read timing", {re_low[15:0], lat[15:0]},
          {TL[15:0], STROBE_LAT[15:0]});
    end

    // R9 busy bit through synchroniser
    nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    fl_byte = 8'hC3;
    xfer(1'b0, '0, rd, lat);
    chk(rd == {8'h0, 8'hC3, 1'b1, 15'h0}, "R9", "busy set", rd, {8'h0, 8'hC3, 1'b1, 15'h0});
    nand_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    xfer(1'b0, '0, rd, lat);
    chk(rd[15] == 1'b0, "R9", "busy clear", rd[15], 0);

    // R8 reserved codes in read mode
    for (int op = 4; op < 8; op++) begin
      for (int en = 0; en < 2; en++) begin
        prev_ce = nand_ce_n;
        xfer(1'b1, mkw(en[0], op, 8'hA5), rd, lat);
        chk(we_falls == 0 && re_falls == 0 && lat == 1, "R8", "reserved no strobe", lat, 1);
        chk(nand_ce_n == prev_ce, "R8", "reserved ce unchanged", nand_ce_n, prev_ce);
        fl_byte = 8'(op * 16 + en);
        xfer(1'b0, '0, rd, lat);
        chk(re_falls == 1 && rd[23:16] == fl_byte, "R8", "read mode kept", rd, {8'h0, fl_byte, 16'h0});
      end
    end

    // R5 read select with enable clear
    xfer(1'b1, mkw(1'b0, 2, 8'h00), rd, lat);
    chk(nand_ce_n == 1'b1, "R5", "ce off from read select", nand_ce_n, 1);

    // R7 exit read mode via each write code
    for (int op = 0; op < 4; op++) begin
      if (op == 2) continue;
      xfer(1'b1, mkw(1'b1, 2, 8'h00), rd, lat);
      xfer(1'b1, mkw(1'b1, op, 8'h3C), rd, lat);
      xfer(1'b0, '0, rd, lat);
      chk(re_falls == 0 && rd == 32'h0 && lat == 1, "R7", "read mode cleared", rd, 32'h0);
    end

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule